// File: doc/BRIEF.md
# Serial Timekeeper Register Slave

This block is the device side of a three-wire timekeeping peripheral. It keeps a BCD calendar in eight byte registers: seconds, minutes, hours, day of month, month, weekday, year and a write-protect flag. A host reaches those registers over a link made of three lines. The first is an active-low link reset that frames each transfer. The second is a serial clock. The third is a data line, which appears here as a separate input, output and output-enable so that a pad cell can close it into one bidirectional wire. A pulse on the one-second tick input advances the calendar by one second. The counting handles carries through minutes, hours, days, months and years, months of different lengths, leap years, and an hours field that is in either 12-hour or 24-hour form.

A transfer starts when the host releases the link reset with the serial clock low. The host then clocks in a command byte. A burst command reads or writes all eight registers in their fixed order, and a separate command writes only the protect flag. The link pins are oversampled by the system clock through synchronizers. The serial protocol has no back-pressure, so the block has no valid/ready stream. The host paces every bit with its own clock, and every link pin is a plain level.

Top module: `tk3w_slave`

## Requirements
- R1: After system reset the registers read seconds 00, minutes 00, hours 00 (24-hour), day 01, month 01, weekday 01, year 00 and protect 0x80. The data output enable is low whenever the link reset is held low.
- R2: Every byte moves least significant bit first. Command 0xBF (bit 0 set means read) returns the registers in burst order: seconds, minutes, hours, day, month, weekday, year, protect. Command 0xBE writes them in the same order.
- R3: A burst write commits each register when its eighth bit arrives. A transfer cut short keeps the bytes already completed and leaves the rest unchanged.
- R4: Command 0x8E followed by one byte writes the protect register. Only bit 7 is kept, and bits 6:0 read as zero.
- R5: While protect bit 7 is set, burst writes to the seven calendar registers are ignored. The protect byte itself, whether sent in the burst or by 0x8E, is always accepted.
- R6: Bits that cannot hold data are stored as zero: seconds bit 7, minutes bit 7, hours bit 6, day bits 7:6, month bits 7:5, weekday bits 7:3. A zero written to day, month or weekday is stored as 01.
- R7: During a read the device changes its output bit only after a falling serial-clock edge, so the bit is steady across the next rising edge. It releases the line while the link reset is low.
- R8: A tick advances seconds in BCD with carries from 59 seconds, from 59 minutes and from hour 23 in 24-hour mode. Weekday wraps from 7 to 1, month 12 rolls over to 01 with a year carry, and year 99 wraps to 00.
- R9: In 12-hour mode (hours bit 7 set, bit 5 = PM, bits 4:0 = BCD 01..12), hour 11 steps to 12 and flips the PM bit, and hour 12 steps to 01 without flipping it. The day advances only on the step from 11 PM to 12 AM.
- R10: The day wraps after 31, 30 or 28 days according to the month. February has 29 days when the BCD year is a multiple of four.
- R11: A tick that arrives while the link reset is high is held and applied once the transfer ends, so the registers do not change mid-transfer.
- R12: Pulling the link reset low in the middle of a byte aborts the transfer, and the next transfer starts with a command byte. A command other than 0xBE, 0xBF or 0x8E is ignored, and the line is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the link |
| rst_n | input | 1 | System reset, active low |
| tick_sec | input | 1 | One-cycle pulse per second |
| link_rst_n | input | 1 | Link reset, active low; high frames a transfer |
| link_clk | input | 1 | Serial clock from the host |
| link_din | input | 1 | Data line as seen by the device |
| link_dout | output | 1 | Data bit driven during a read |
| link_oe | output | 1 | Output enable for the data line |

## Verification
The link is driven with several command patterns: burst reads, burst writes with protection set and with it clear, protect-only writes, a write cut off after three bytes and four loose bits, and an unknown command. Together they separate command decoding, per-byte commit, protection gating and the abort path. Register contents are chosen so that the masked bits and the zero-to-01 fix-up are visible on readback. Tick tests start from values just before each carry boundary: a BCD nibble carry, the full year rollover, each 12-hour turnover, February in leap and non-leap years, and a 30-day month. One tick is also issued inside a read transfer, which shows whether the tick is held until the transfer ends.

// File: rtl/tk_pkg.sv
package tk_pkg;
  localparam int BYTE_W = 8;
  localparam int NREG   = 8;
  localparam int IDX_W  = $clog2(NREG);
  localparam int FLAT_W = BYTE_W * NREG;

  // burst order is behaviour: index = position in a burst
  localparam logic [IDX_W-1:0] IX_SEC  = 3'd0;
  localparam logic [IDX_W-1:0] IX_MIN  = 3'd1;
  localparam logic [IDX_W-1:0] IX_HOUR = 3'd2;
  localparam logic [IDX_W-1:0] IX_DAY  = 3'd3;
  localparam logic [IDX_W-1:0] IX_MON  = 3'd4;
  localparam logic [IDX_W-1:0] IX_WDAY = 3'd5;
  localparam logic [IDX_W-1:0] IX_YEAR = 3'd6;
  localparam logic [IDX_W-1:0] IX_WP   = 3'd7;

  localparam logic [BYTE_W-1:0] CMD_BURST_WR = 8'hBE;
  localparam logic [BYTE_W-1:0] CMD_BURST_RD = 8'hBF;
  localparam logic [BYTE_W-1:0] CMD_WP_WR    = 8'h8E;

  typedef enum logic [2:0] {
    PH_CMD, PH_WR, PH_RD, PH_WP, PH_SKIP
  } link_phase_e;

  function automatic logic [BYTE_W-1:0] keep_mask(logic [IDX_W-1:0] ix);
    case (ix)
      IX_SEC, IX_MIN: return 8'h7F;
      IX_HOUR:        return 8'hBF;
      IX_DAY:         return 8'h3F;
      IX_MON:         return 8'h1F;
      IX_WDAY:        return 8'h07;
      IX_YEAR:        return 8'hFF;
      default:        return 8'h80;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] reset_val(logic [IDX_W-1:0] ix);
    case (ix)
      IX_DAY, IX_MON, IX_WDAY: return 8'h01;
      IX_WP:                   return 8'h80;
      default:                 return 8'h00;
    endcase
  endfunction

  // store form of a host byte: masked, and never zero where zero is illegal
  function automatic logic [BYTE_W-1:0] store_form(logic [IDX_W-1:0] ix,
                                                    logic [BYTE_W-1:0] d);
    logic [BYTE_W-1:0] m;
    m = d & keep_mask(ix);
    if ((ix == IX_DAY || ix == IX_MON || ix == IX_WDAY) && m == '0)
      m = 8'h01;
    return m;
  endfunction

  function automatic logic [BYTE_W-1:0] bcd_inc(logic [BYTE_W-1:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  function automatic logic leap_bcd(logic [BYTE_W-1:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [BYTE_W-1:0] last_day(logic [BYTE_W-1:0] mon,
                                                  logic [BYTE_W-1:0] yr);
    case (mon)
      8'h02:                      return leap_bcd(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/tk_sync.sv
module tk_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[g] <= '0;
        else if (g == 0) st[g] <= d;
        else st[g] <= st[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/tk_serial.sv
module tk_serial
  import tk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_act,
  input  logic              sclk,
  input  logic              sdin,
  input  logic [FLAT_W-1:0] regs_flat,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [BYTE_W-1:0] wr_data,
  output logic              dout,
  output logic              doe,
  output logic              rd_phase
);
  link_phase_e       ph;
  logic              sclk_d;
  logic [2:0]        bcnt;
  logic [BYTE_W-2:0] rxsh;
  logic [BYTE_W-1:0] txsh;
  logic [IDX_W-1:0]  idx;
  logic [BYTE_W-1:0] rx_next;
  logic              rise, fall;

  assign rise     = sclk & ~sclk_d;
  assign fall     = ~sclk & sclk_d;
  assign rx_next  = {sdin, rxsh};
  assign rd_phase = (ph == PH_RD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_CMD;
      sclk_d  <= 1'b0;
      bcnt    <= '0;
      rxsh    <= '0;
      txsh    <= '0;
      idx     <= '0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
      dout    <= 1'b0;
      doe     <= 1'b0;
    end else begin
      wr_en  <= 1'b0;
      sclk_d <= sclk;
      if (!ce_act) begin
        ph   <= PH_CMD;
        bcnt <= '0;
        doe  <= 1'b0;
        dout <= 1'b0;
      end else begin
        if (rise) begin
          rxsh <= rx_next[BYTE_W-1:1];
          bcnt <= bcnt + 3'd1;
          if (ph == PH_RD) begin
            if (bcnt == 3'd7) begin
              txsh <= regs_flat[idx*BYTE_W +: BYTE_W];
              idx  <= idx + 1'b1;
            end else begin
              txsh <= txsh >> 1;
            end
          end
          if (bcnt == 3'd7) begin
            case (ph)
              PH_CMD: begin
                idx <= '0;
                if (rx_next == CMD_BURST_RD) begin
                  ph   <= PH_RD;
                  txsh <= regs_flat[BYTE_W-1:0];
                  idx  <= 3'd1;
                end else if (rx_next == CMD_BURST_WR) ph <= PH_WR;
                else if (rx_next == CMD_WP_WR)        ph <= PH_WP;
                else                                  ph <= PH_SKIP;
              end
              PH_WR: begin
                wr_en   <= 1'b1;
                wr_idx  <= idx;
                wr_data <= rx_next;
                idx     <= idx + 1'b1;
                if (idx == IX_WP) ph <= PH_SKIP;
              end
              PH_WP: begin
                wr_en   <= 1'b1;
                wr_idx  <= IX_WP;
                wr_data <= rx_next;
                ph      <= PH_SKIP;
              end
              default: ;
            endcase
          end
        end
        if (fall && ph == PH_RD) begin
          doe  <= 1'b1;
          dout <= txsh[0];
        end
      end
    end
  end
endmodule

// File: rtl/tk_regfile.sv
module tk_regfile
  import tk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [FLAT_W-1:0] regs_flat
);
  logic [BYTE_W-1:0] r  [NREG];
  logic [BYTE_W-1:0] nx [NREG];
  logic              pend, apply;
  logic              c_min, c_hr, c_day, c_mon, c_yr;
  logic [BYTE_W-1:0] h12;

  assign apply = (tick | pend) & ~busy & ~wr_en;

  // next calendar state for one second
  always_comb begin
    for (int i = 0; i < NREG; i++) nx[i] = r[i];
    c_hr  = 1'b0;
    c_day = 1'b0;
    c_mon = 1'b0;
    c_yr  = 1'b0;
    h12   = bcd_inc({3'b000, r[IX_HOUR][4:0]});
    c_min = (r[IX_SEC][6:0] == 7'h59);
    nx[IX_SEC] = c_min ? 8'h00 : bcd_inc(r[IX_SEC]);
    if (c_min) begin
      c_hr = (r[IX_MIN] == 8'h59);
      nx[IX_MIN] = c_hr ? 8'h00 : bcd_inc(r[IX_MIN]);
    end
    if (c_min && c_hr) begin
      if (r[IX_HOUR][7]) begin
        if (r[IX_HOUR][4:0] == 5'h12) begin
          nx[IX_HOUR] = {2'b10, r[IX_HOUR][5], 5'h01};
        end else if (r[IX_HOUR][4:0] == 5'h11) begin
          nx[IX_HOUR] = {2'b10, ~r[IX_HOUR][5], 5'h12};
          c_day = r[IX_HOUR][5];
        end else begin
          nx[IX_HOUR] = {2'b10, r[IX_HOUR][5], h12[4:0]};
        end
      end else if (r[IX_HOUR] == 8'h23) begin
        nx[IX_HOUR] = 8'h00;
        c_day = 1'b1;
      end else begin
        nx[IX_HOUR] = bcd_inc(r[IX_HOUR]);
      end
    end
    if (c_day) begin
      nx[IX_WDAY] = (r[IX_WDAY] == 8'h07) ? 8'h01 : r[IX_WDAY] + 8'h01;
      c_mon = (r[IX_DAY] == last_day(r[IX_MON], r[IX_YEAR]));
      nx[IX_DAY] = c_mon ? 8'h01 : bcd_inc(r[IX_DAY]);
    end
    if (c_mon) begin
      c_yr = (r[IX_MON] == 8'h12);
      nx[IX_MON] = c_yr ? 8'h01 : bcd_inc(r[IX_MON]);
    end
    if (c_yr) nx[IX_YEAR] = (r[IX_YEAR] == 8'h99) ? 8'h00 : bcd_inc(r[IX_YEAR]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) r[i] <= reset_val(IDX_W'(i));
      pend <= 1'b0;
    end else begin
      if (apply) pend <= 1'b0;
      else if (tick) pend <= 1'b1;
      if (wr_en) begin
        if (wr_idx == IX_WP || !r[IX_WP][7]) r[wr_idx] <= store_form(wr_idx, wr_data);
      end else if (apply) begin
        for (int i = 0; i < NREG; i++) r[i] <= nx[i];
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_flat
      assign regs_flat[g*BYTE_W +: BYTE_W] = r[g];
    end
  endgenerate
endmodule

// File: rtl/tk3w_slave.sv
module tk3w_slave
  import tk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_sec,
  input  logic link_rst_n,
  input  logic link_clk,
  input  logic link_din,
  output logic link_dout,
  output logic link_oe
);
  logic [2:0]        sync_q;
  logic              ce_act, sclk_s, sdin_s;
  logic              wr_en, rd_phase;
  logic [IDX_W-1:0]  wr_idx;
  logic [BYTE_W-1:0] wr_data;
  logic [FLAT_W-1:0] regs_flat;

  tk_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({link_rst_n, link_clk, link_din}),
    .q    (sync_q)
  );
  assign {ce_act, sclk_s, sdin_s} = sync_q;

  tk_serial u_ser (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_act   (ce_act),
    .sclk     (sclk_s),
    .sdin     (sdin_s),
    .regs_flat(regs_flat),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .dout     (link_dout),
    .doe      (link_oe),
    .rd_phase (rd_phase)
  );

  tk_regfile u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (ce_act),
    .tick     (tick_sec),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .regs_flat(regs_flat)
  );
endmodule

// File: rtl/tk3w_checker.sv
module tk3w_checker
  import tk_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ce_act,
  input logic              oe,
  input logic              rd_phase,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [FLAT_W-1:0] regs_flat
);
  // R7: line released one cycle after the link goes idle
  a_r7_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_act |=> !oe);

  // R7: line driven only in the read phase
  a_r7_drive_only_reading: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> rd_phase);

  // R5: protected calendar registers keep their value on a write
  a_r5_protect_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx != IX_WP && regs_flat[FLAT_W-1]) |=> $stable(regs_flat[FLAT_W-BYTE_W-1:0]));

  // R11: no tick lands while a transfer is open
  a_r11_tick_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_act && !wr_en) |=> $stable(regs_flat));

  // R6: fixed-zero bits
  always @(posedge clk) begin
    if (rst_n) begin
      a_r6_zero_bits: assert (regs_flat[7] == 1'b0 && regs_flat[15] == 1'b0 &&
                              regs_flat[22] == 1'b0 && regs_flat[31:30] == 2'b00 &&
                              regs_flat[39:37] == 3'b000 && regs_flat[47:43] == 5'b00000 &&
                              regs_flat[62:56] == 7'b0000000);
    end
  end
endmodule

bind tk3w_slave tk3w_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ce_act   (ce_act),
  .oe       (link_oe),
  .rd_phase (rd_phase),
  .wr_en    (wr_en),
  .wr_idx   (wr_idx),
  .regs_flat(regs_flat)
);

// File: tb/tk3w_slave_bench.sv
module tk3w_slave_bench;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_sec = 1'b0;
  logic link_rst_n = 1'b0;
  logic link_clk = 1'b0;
  logic link_din = 1'b0;
  logic link_dout, link_oe;

  int total = 0;
  int bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] rx_val;
  event       rx_ev;

  always #4 clk = ~clk;

  tk3w_slave u_tk3w_slave (
    .clk(clk), .rst_n(rst_n), .tick_sec(tick_sec),
    .link_rst_n(link_rst_n), .link_clk(link_clk), .link_din(link_din),
    .link_dout(link_dout), .link_oe(link_oe)
  );

  function automatic logic [63:0] pk(logic [7:0] a0, logic [7:0] a1, logic [7:0] a2,
                                     logic [7:0] a3, logic [7:0] a4, logic [7:0] a5,
                                     logic [7:0] a6, logic [7:0] a7);
    return {a7, a6, a5, a4, a3, a2, a1, a0};
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // monitor: pops expected bytes as the device returns them
  initial begin
    forever begin
      @(rx_ev);
      if (exp_q.size() == 0) check("unexpected byte", rx_val, 8'hxx);
      else check(tag_q.pop_front(), rx_val, exp_q.pop_front());
    end
  end

  task automatic wait_h(int n);
    repeat (n * H) @(negedge clk);
  endtask

  task automatic xfer_begin();
    @(negedge clk);
    link_clk = 1'b0;
    link_rst_n = 1'b1;
    wait_h(1);
  endtask

  task automatic xfer_end();
    @(negedge clk);
    link_clk = 1'b0;
    link_rst_n = 1'b0;
    wait_h(2);
  endtask

  task automatic send_byte(logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      link_din = b[i];
      wait_h(1);
      link_clk = 1'b1;
      wait_h(1);
      link_clk = 1'b0;
    end
  endtask

  task automatic recv_byte();
    logic [7:0] b;
    for (int i = 0; i < 8; i++) begin
      wait_h(1);
      link_clk = 1'b1;
      wait_h(1);
      b[i] = link_dout;
      link_clk = 1'b0;
    end
    rx_val = b;
    ->rx_ev;
  endtask

  task automatic read_expect(logic [63:0] e, string tag);
    for (int i = 0; i < 8; i++) begin
      exp_q.push_back(e[8*i +: 8]);
      tag_q.push_back($sformatf("%s byte%0d", tag, i));
    end
    xfer_begin();
    send_byte(8'hBF);
    for (int i = 0; i < 8; i++) recv_byte();
    xfer_end();
  endtask

  task automatic burst_write(logic [63:0] v);
    xfer_begin();
    send_byte(8'hBE);
    for (int i = 0; i < 8; i++) send_byte(v[8*i +: 8]);
    xfer_end();
  endtask

  task automatic wp_write(logic [7:0] v);
    xfer_begin();
    send_byte(8'h8E);
    send_byte(v);
    xfer_end();
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick_sec = 1'b1;
    @(negedge clk);
    tick_sec = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic tick_case(logic [63:0] start, logic [63:0] e, string tag);
    burst_write(start);
    pulse_tick();
    read_expect(e, tag);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 oe idle", {7'd0, link_oe}, 8'h00);
    // R1 R2: reset values in burst order
    read_expect(pk(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h80), "R1 R2 reset");
    // R5: protected burst ignored
    burst_write(pk(8'h12, 8'h34, 8'h05, 8'h06, 8'h07, 8'h02, 8'h44, 8'h80));
    read_expect(pk(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h80), "R5 protected");
    // R4: clear protect alone
    wp_write(8'h00);
    read_expect(pk(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00), "R4 clear");
    // R6 R2: masks and zero fix-up
    burst_write(pk(8'h45, 8'hB7, 8'h61, 8'h00, 8'hE9, 8'h0D, 8'h23, 8'h00));
    read_expect(pk(8'h45, 8'h37, 8'h21, 8'h01, 8'h09, 8'h05, 8'h23, 8'h00), "R6 masks");
    // R4: only bit 7 kept
    wp_write(8'hFF);
    read_expect(pk(8'h45, 8'h37, 8'h21, 8'h01, 8'h09, 8'h05, 8'h23, 8'h80), "R4 bit7");
    // R5: burst protect byte accepted, calendar bytes not
    burst_write(pk(8'h11, 8'h11, 8'h11, 8'h11, 8'h11, 8'h01, 8'h11, 8'h00));
    read_expect(pk(8'h45, 8'h37, 8'h21, 8'h01, 8'h09, 8'h05, 8'h23, 8'h00), "R5 wp in burst");
    // R3 R12: aborted burst keeps completed bytes
    xfer_begin();
    send_byte(8'hBE);
    send_byte(8'h11);
    send_byte(8'h22);
    send_byte(8'h13);
    for (int i = 0; i < 4; i++) begin
      link_din = 1'b1;
      wait_h(1);
      link_clk = 1'b1;
      wait_h(1);
      link_clk = 1'b0;
    end
    xfer_end();
    read_expect(pk(8'h11, 8'h22, 8'h13, 8'h01, 8'h09, 8'h05, 8'h23, 8'h00), "R3 R12 abort");
    // R12: unknown command never drives the line
    xfer_begin();
    send_byte(8'h81);
    begin
      logic seen;
      seen = 1'b0;
      for (int i = 0; i < 16; i++) begin
        wait_h(1);
        link_clk = 1'b1;
        wait_h(1);
        seen = seen | link_oe;
        link_clk = 1'b0;
      end
      check("R12 unknown cmd oe", {7'd0, seen}, 8'h00);
    end
    xfer_end();
    // R8: full rollover
    tick_case(pk(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h07, 8'h99, 8'h00),
              pk(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00), "R8 year rollover");
    tick_case(pk(8'h59, 8'h59, 8'h09, 8'h15, 8'h06, 8'h03, 8'h24, 8'h00),
              pk(8'h00, 8'h00, 8'h10, 8'h15, 8'h06, 8'h03, 8'h24, 8'h00), "R8 hour nibble");
    // R9 R10: 11 PM -> 12 AM onto Feb 29 of a leap year
    tick_case(pk(8'h59, 8'h59, 8'hB1, 8'h28, 8'h02, 8'h02, 8'h24, 8'h00),
              pk(8'h00, 8'h00, 8'h92, 8'h29, 8'h02, 8'h03, 8'h24, 8'h00), "R9 R10 pm to am leap");
    tick_case(pk(8'h59, 8'h59, 8'h92, 8'h10, 8'h03, 8'h04, 8'h24, 8'h00),
              pk(8'h00, 8'h00, 8'h81, 8'h10, 8'h03, 8'h04, 8'h24, 8'h00), "R9 12am to 1am");
    tick_case(pk(8'h59, 8'h59, 8'h91, 8'h10, 8'h03, 8'h04, 8'h24, 8'h00),
              pk(8'h00, 8'h00, 8'hB2, 8'h10, 8'h03, 8'h04, 8'h24, 8'h00), "R9 11am to 12pm");
    // R10: non-leap February, 30-day month
    tick_case(pk(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h05, 8'h23, 8'h00),
              pk(8'h00, 8'h00, 8'h00, 8'h01, 8'h03, 8'h06, 8'h23, 8'h00), "R10 feb plain");
    tick_case(pk(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h06, 8'h23, 8'h00),
              pk(8'h00, 8'h00, 8'h00, 8'h01, 8'h05, 8'h07, 8'h23, 8'h00), "R10 april");
    // R11: tick inside a read transfer is held
    burst_write(pk(8'h05, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00));
    for (int i = 0; i < 8; i++) begin
      exp_q.push_back(i == 0 ? 8'h05 : (i < 3 ? 8'h00 : (i == 6 || i == 7 ? 8'h00 : 8'h01)));
      tag_q.push_back($sformatf("R11 during byte%0d", i));
    end
    xfer_begin();
    send_byte(8'hBF);
    pulse_tick();
    for (int i = 0; i < 8; i++) recv_byte();
    xfer_end();
    read_expect(pk(8'h06, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00), "R11 after");
    check("R1 queue drained", 8'(exp_q.size()), 8'h00);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule